// File: doc/BRIEF.md
# Lockable Feature-Control Gating Unit

This unit holds a feature-control register that firmware programs once and then freezes by setting its lock bit. Two fields in that register grant permissions. The first is an enable for a set of enclave extensions. The second is a write-enable for a bank of four 64-bit launch-key hash registers, which together hold a 256-bit digest. Both permissions take effect only while the register is locked.

The register and the hash bank are reached over a simple single-cycle address/data request bus. Read data and a one-cycle error pulse are registered and appear one clock after the request. A strap input tells the unit whether the basic enclave leaf set is supported. When that strap is low, the hash bank behaves as absent.

Extension availability also depends on the current processor mode:
- protected mode and paging must both be on;
- system-management mode and virtual-8086 mode must both be off.

The availability output and the hash write-permit output are combinational. They follow the mode inputs and the strap within the same cycle. The enable bit is not reported on any capability path, so software learns it only by reading the control register.

Top module: `fctl_gate`

## Requirements
- R1: After reset the control register and all four hash words read as zero, and `ext_avail`, `hash_wr_ok` and `rsp_err` are low.
- R2: While bit 0 (lock) of the control register is 0, a write to address 0 stores the full 64-bit value with no error. A read of address 0 returns the stored value one cycle after the request. Writing a value with bit 0 set locks the register.
- R3: Once the lock bit is 1, every write to address 0 raises `rsp_err` for one cycle and leaves the register unchanged until reset.
- R4: `ext_avail` is high only when control bit 18 (enable) and bit 0 (lock) are both 1 and the mode is qualified. Bit 18 set without the lock gives no availability.
- R5: A mode is qualified when `cpu_prot` and `cpu_paging` are high and both `cpu_smm` and `cpu_v86` are low. `ext_avail` follows a mode change in the same cycle, with no clock edge needed.
- R6: `hash_wr_ok` equals control bit 17 AND bit 0 AND `leaf_sup`. Writes to addresses 4 to 7 (hash words 0 to 3) are stored only while it is high. Each word reads back at its own address.
- R7: A write to a hash word while `hash_wr_ok` is low leaves every hash word unchanged and raises `rsp_err`.
- R8: While `leaf_sup` is low, any read or write of addresses 4 to 7 raises `rsp_err` and a read returns zero. The stored hash words are preserved, and they read back once the strap returns high.
- R9: Any request to addresses 1 to 3 raises `rsp_err`, and a read of those addresses returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 3 | Word address: 0 for the control register, 4 to 7 for the hash words |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, registered; holds its value until the next read |
| rsp_err | output | 1 | One-cycle pulse after a rejected request |
| cpu_prot | input | 1 | Protected mode active |
| cpu_smm | input | 1 | System-management mode active |
| cpu_v86 | input | 1 | Virtual-8086 mode active |
| cpu_paging | input | 1 | Paging enable bit |
| leaf_sup | input | 1 | Strap: basic enclave leaf set supported |
| ext_avail | output | 1 | Enclave extensions available |
| hash_wr_ok | output | 1 | Hash registers writable |

## Verification
Most internal faults reach the ports with very little delay. A corrupted lock or enable bit shows at once on `ext_avail` or `hash_wr_ok`, because both outputs are combinational from the stored state. A wrongly accepted or wrongly rejected write shows one cycle after its request on `rsp_err`. A control register or hash word that changed when it should not have appears in the data returned by the next read of that address, also one cycle after that read. The mode and strap checks are made within the same cycle as the input change, so a misplaced register on those paths would also be caught.

// File: rtl/fctl_pkg.sv
package fctl_pkg;
    localparam int DATA_W     = 64;
    localparam int ADDR_W     = 3;
    localparam int HASH_WORDS = 4;
    localparam int HASH_BASE  = 4;
    localparam int CTRL_ADDR  = 0;
    localparam int LOCK_BIT   = 0;
    localparam int KEYWR_BIT  = 17;
    localparam int ENABLE_BIT = 18;

    typedef enum logic [1:0] {
        RGN_CTRL,
        RGN_HASH,
        RGN_NONE
    } region_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Map a word address onto the region it selects.
    function automatic region_e decode(input logic [ADDR_W-1:0] a);
        if (int'(a) == CTRL_ADDR) return RGN_CTRL;
        if (int'(a) >= HASH_BASE && int'(a) < HASH_BASE + HASH_WORDS) return RGN_HASH;
        return RGN_NONE;
    endfunction
endpackage

// File: rtl/fctl_ctrl_reg.sv
module fctl_ctrl_reg #(
    parameter int W    = 64,
    parameter int LOCK = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_q,
    output logic         locked,
    output logic         reject
);
    assign locked = ctrl_q[LOCK];
    assign reject = wr_en && locked;

    always_ff @(posedge clk) begin
        if (rst)                  ctrl_q <= '0;
        else if (wr_en && !locked) ctrl_q <= wdata;
    end

    // R3: a locked register never changes on the following edge
    a_r3_locked_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(ctrl_q));
endmodule

// File: rtl/fctl_hash_bank.sv
module fctl_hash_bank #(
    parameter int WORDS = 4,
    parameter int W     = 64,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    input  logic             permit,
    output logic [W-1:0]     rd_word,
    output logic             reject
);
    logic [WORDS-1:0][W-1:0] mem;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                                            mem[i] <= '0;
            else if (wr_en && permit && idx == IDX_W'(i))       mem[i] <= wdata;
        end
    end

    assign rd_word = mem[idx];
    assign reject  = wr_en && !permit;

    // R7: while writes are not permitted, no hash word changes
    a_r7_ro_hold: assert property (@(posedge clk) disable iff (rst)
        !permit |=> $stable(mem));
endmodule

// File: rtl/fctl_mode_qual.sv
module fctl_mode_qual (
    input  logic prot,
    input  logic smm,
    input  logic v86,
    input  logic paging,
    output logic mode_ok
);
    assign mode_ok = prot && paging && !smm && !v86;
endmodule

// File: rtl/fctl_gate.sv
module fctl_gate
    import fctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    input  logic              cpu_prot,
    input  logic              cpu_smm,
    input  logic              cpu_v86,
    input  logic              cpu_paging,
    input  logic              leaf_sup,
    output logic              ext_avail,
    output logic              hash_wr_ok
);
    localparam int IDX_W = (HASH_WORDS > 1) ? $clog2(HASH_WORDS) : 1;

    bus_req_t          req;
    region_e           rgn;
    logic [DATA_W-1:0] ctrl_q, hash_word;
    logic              locked, ctrl_rej, hash_rej, mode_ok;
    logic              ctrl_wr, hash_wr, bad;
    logic [IDX_W-1:0]  hash_idx;

    assign req      = '{valid: req_valid, write: req_write, addr: req_addr, wdata: req_wdata};
    assign rgn      = decode(req.addr);
    assign hash_idx = IDX_W'(req.addr - ADDR_W'(HASH_BASE));
    assign ctrl_wr  = req.valid && req.write && rgn == RGN_CTRL;
    assign hash_wr  = req.valid && req.write && rgn == RGN_HASH && leaf_sup;

    fctl_ctrl_reg #(.W(DATA_W), .LOCK(LOCK_BIT)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(req.wdata),
        .ctrl_q(ctrl_q), .locked(locked), .reject(ctrl_rej)
    );

    fctl_hash_bank #(.WORDS(HASH_WORDS), .W(DATA_W)) u_hash (
        .clk(clk), .rst(rst), .wr_en(hash_wr), .idx(hash_idx), .wdata(req.wdata),
        .permit(hash_wr_ok), .rd_word(hash_word), .reject(hash_rej)
    );

    fctl_mode_qual u_mode (
        .prot(cpu_prot), .smm(cpu_smm), .v86(cpu_v86), .paging(cpu_paging),
        .mode_ok(mode_ok)
    );

    assign ext_avail  = ctrl_q[ENABLE_BIT] && locked && mode_ok;
    assign hash_wr_ok = ctrl_q[KEYWR_BIT] && locked && leaf_sup;

    assign bad = req.valid && (rgn == RGN_NONE || (rgn == RGN_HASH && !leaf_sup)
                               || ctrl_rej || hash_rej);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_err <= bad;
            if (req.valid && !req.write) begin
                if (rgn == RGN_CTRL)                  rsp_rdata <= ctrl_q;
                else if (rgn == RGN_HASH && leaf_sup) rsp_rdata <= hash_word;
                else                                  rsp_rdata <= '0;
            end
        end
    end

    // R3: a write to a locked control register is answered with an error
    a_r3_err_on_locked: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == ADDR_W'(CTRL_ADDR) && locked) |=> rsp_err);
    // R5: availability never coexists with a disqualified mode
    a_r5_avail_mode: assert property (@(posedge clk) disable iff (rst)
        ext_avail |-> mode_ok);
    // R8: any hash access with the strap low is rejected
    a_r8_strap_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rgn == RGN_HASH && !leaf_sup) |=> rsp_err);
    // R9: unmapped addresses always error
    a_r9_unmapped_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rgn == RGN_NONE) |=> rsp_err);
    // R1: the register leaves reset cleared
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_q == '0 && !rsp_err));
endmodule

// File: tb/test_fctl_gate.sv
`timescale 1ns/1ps
module test_fctl_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic        cpu_prot = 1'b1, cpu_smm = 1'b0, cpu_v86 = 1'b0, cpu_paging = 1'b1;
    logic        leaf_sup = 1'b1;
    logic        ext_avail, hash_wr_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [63:0] B_LOCK = 64'h1;
    localparam logic [63:0] B_KWR  = 64'h1 << 17;
    localparam logic [63:0] B_EN   = 64'h1 << 18;

    always #2.5 clk = ~clk;

    fctl_gate i_fctl_gate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .cpu_prot(cpu_prot), .cpu_smm(cpu_smm),
        .cpu_v86(cpu_v86), .cpu_paging(cpu_paging), .leaf_sup(leaf_sup),
        .ext_avail(ext_avail), .hash_wr_ok(hash_wr_ok)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request; outputs sampled on the following falling edge.
    task automatic bus(input logic wr, input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ext_avail", 64'(ext_avail), 64'd0);
        chk("R1 hash_wr_ok", 64'(hash_wr_ok), 64'd0);
        chk("R1 rsp_err", 64'(rsp_err), 64'd0);
        bus(0, 3'd0, '0);
        chk("R1 ctrl read", rsp_rdata, 64'd0);
        for (int i = 4; i < 8; i++) begin
            bus(0, 3'(i), '0);
            chk("R1 hash read", rsp_rdata, 64'd0);
        end
    endtask

    task automatic t_unlocked;
        bus(1, 3'd0, B_EN | B_KWR | 64'hA5A5_0000_0000_0000);
        chk("R2 write err", 64'(rsp_err), 64'd0);
        bus(0, 3'd0, '0);
        chk("R2 readback", rsp_rdata, B_EN | B_KWR | 64'hA5A5_0000_0000_0000);
        chk("R4 no avail unlocked", 64'(ext_avail), 64'd0);
        chk("R6 no permit unlocked", 64'(hash_wr_ok), 64'd0);
        bus(1, 3'd5, 64'hDEAD_BEEF_0000_1111);
        chk("R7 ro write err", 64'(rsp_err), 64'd1);
        bus(0, 3'd5, '0);
        chk("R7 ro unchanged", rsp_rdata, 64'd0);
    endtask

    task automatic t_unmapped;
        bus(1, 3'd2, 64'h1234);
        chk("R9 write unmapped err", 64'(rsp_err), 64'd1);
        bus(0, 3'd0, '0);
        bus(0, 3'd3, '0);
        chk("R9 read unmapped err", 64'(rsp_err), 64'd1);
        chk("R9 read unmapped data", rsp_rdata, 64'd0);
    endtask

    task automatic t_lock;
        bus(1, 3'd0, B_EN | B_KWR | B_LOCK);
        chk("R2 lock write err", 64'(rsp_err), 64'd0);
        chk("R4 avail locked", 64'(ext_avail), 64'd1);
        chk("R6 permit locked", 64'(hash_wr_ok), 64'd1);
        bus(1, 3'd0, 64'd0);
        chk("R3 locked write err", 64'(rsp_err), 64'd1);
        bus(0, 3'd0, '0);
        chk("R3 locked unchanged", rsp_rdata, B_EN | B_KWR | B_LOCK);
        chk("R3 avail kept", 64'(ext_avail), 64'd1);
    endtask

    task automatic t_modes;
        @(negedge clk);
        cpu_smm = 1'b1; #1;
        chk("R5 smm denies", 64'(ext_avail), 64'd0);
        cpu_smm = 1'b0; cpu_v86 = 1'b1; #1;
        chk("R5 v86 denies", 64'(ext_avail), 64'd0);
        cpu_v86 = 1'b0; cpu_prot = 1'b0; #1;
        chk("R5 real mode denies", 64'(ext_avail), 64'd0);
        cpu_prot = 1'b1; cpu_paging = 1'b0; #1;
        chk("R5 no paging denies", 64'(ext_avail), 64'd0);
        cpu_paging = 1'b1; #1;
        chk("R5 qualified", 64'(ext_avail), 64'd1);
    endtask

    task automatic t_hash;
        for (int i = 0; i < 4; i++) begin
            bus(1, 3'(4 + i), 64'h0101_0101_0101_0101 * 64'(i + 3));
            chk("R6 hash write err", 64'(rsp_err), 64'd0);
        end
        for (int i = 0; i < 4; i++) begin
            bus(0, 3'(4 + i), '0);
            chk("R6 hash readback", rsp_rdata, 64'h0101_0101_0101_0101 * 64'(i + 3));
        end
    endtask

    task automatic t_strap;
        @(negedge clk);
        leaf_sup = 1'b0; #1;
        chk("R6 permit needs strap", 64'(hash_wr_ok), 64'd0);
        bus(1, 3'd4, 64'hFFFF);
        chk("R8 write err", 64'(rsp_err), 64'd1);
        bus(0, 3'd4, '0);
        chk("R8 read err", 64'(rsp_err), 64'd1);
        chk("R8 read zero", rsp_rdata, 64'd0);
        @(negedge clk);
        leaf_sup = 1'b1;
        bus(0, 3'd4, '0);
        chk("R8 read ok err", 64'(rsp_err), 64'd0);
        chk("R8 preserved", rsp_rdata, 64'h0303_0303_0303_0303);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unlocked();
        t_unmapped();
        t_lock();
        t_modes();
        t_hash();
        t_strap();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule